// File: doc/BRIEF.md
# Inquiry and Inquiry-Scan Slot Controller

This block sequences one device through device discovery, acting either as the inquirer that probes for neighbours or as the scanner that answers. It is paced by a half-slot tick, which arrives together with each increment of the device's native clock, and by an internal fine timer that counts one unit per clock cycle since the last tick. The radio is reduced to strobes: the controller asks for an ID or FHS transmission, opens a receive window, and learns of received packets through detect inputs. It does not compute hop frequencies itself. Instead it tells a neighbouring hop kernel which hop flavour to use and which clock snapshot to feed it.

As inquirer, the controller waits for a slot boundary. It then sends an ID in each half of the transmit slot. It opens its receive window a fixed margin before the next tick, on the response hop of the next clock value, and then listens on the current clock's response hop for the whole receive slot. When an FHS arrives while it is listening, the controller finishes. Otherwise it returns to transmitting. As scanner, it listens on the scan hop until an ID is detected. It then waits exactly two half-slots and sends an FHS on the response hop, bumping the responder's counter as it does so. Both roles end in a sticky finished state that only reset leaves.

Top module: `inquiry_slot_ctrl`

## Requirements
- R1: After reset, all strobes, `rxEn` and `finished` are 0. The controller stays idle while `nativeClk` is all ones, and leaves idle in the first cycle in which the clock is not all ones.
- R2: As inquirer, the first ID is requested only for a cycle in which `nativeClk[1:0]` is 00. `idTx` is high for one cycle, one cycle later, with `hopSel` = 0 (inquiry hop) and `hopClk` equal to that clock value.
- R3: The second ID of the transmit slot is requested in the first cycle in which `nativeClk[0]` is 1, with `hopClk` equal to that clock value.
- R4: `rxEn` rises exactly `HALF_SLOT - UNC_DELAY` (615) cycles after the tick of the second ID's half-slot, with `hopSel` = 2 (response hop) and `hopClk` equal to the current clock plus one.
- R5: After the next tick, while `nativeClk[1]` is 1, `rxEn` stays high with `hopClk` equal to the current clock. When bit 1 returns to 0, `rxEn` falls one cycle after that tick, and the next ID follows one cycle later.
- R6: An FHS detect in a cycle with `rxEn` high makes `finished` and `done` rise one cycle later. An FHS detect while `rxEn` is low has no effect.
- R7: As scanner, `rxEn` is high with `hopSel` = 1 (scan hop), and `hopClk` follows `nativeClk` one cycle after every tick.
- R8: An ID detect while scanning drops `rxEn` one cycle later. `fhsTx`, `nInc` and `done` pulse exactly 2*`HALF_SLOT` (1250) cycles after the detect cycle, with `hopSel` = 2 and `hopClk` equal to the clock of the cycle before.
- R9: `done` lasts one cycle and `finished` stays high until reset. After finishing, no `idTx`, `fhsTx` or `rxEn` occurs.
- R10: `roleInquirer` (1 = inquirer, 0 = scanner) is sampled only when leaving idle. A later change has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one fine-timer unit |
| rstN | input | 1 | Asynchronous active-low reset |
| halfTick | input | 1 | High for the first cycle of every half-slot |
| nativeClk | input | CLK_W | Native clock value, incremented together with `halfTick` |
| roleInquirer | input | 1 | 1 selects inquirer, 0 selects scanner |
| idRxDet | input | 1 | ID packet detected by the radio |
| fhsRxDet | input | 1 | FHS packet detected by the radio |
| idTx | output | 1 | One-cycle request to transmit an ID |
| fhsTx | output | 1 | One-cycle request to transmit an FHS |
| nInc | output | 1 | One-cycle request to increment the response counter N |
| rxEn | output | 1 | Receiver listening |
| hopSel | output | 2 | Hop flavour: 0 inquiry, 1 scan, 2 response |
| hopClk | output | CLK_W | Clock snapshot for the hop kernel |
| done | output | 1 | One-cycle pulse on entering the finished state |
| finished | output | 1 | Sticky finished flag |

## Verification
Every strobe and hop update is registered, so it appears at the ports one cycle after the input cycle that causes it. The exceptions are the two timed results: the early receive window appears 615 cycles after its half-slot tick, and the scanner's FHS appears 1250 cycles after the ID-detect cycle. The bench counts cycles from the observed tick or detect and samples 2 ns after each rising edge. It checks the cycle before each due time as well as the due time itself, so a window that opens early or late by one cycle is caught. Clock snapshots are compared against the clock value the bench drove in the causing cycle.

// File: rtl/inq_slot_pkg.sv
package inq_slot_pkg;

  typedef enum logic [1:0] {
    HOP_INQ  = 2'd0,
    HOP_SCAN = 2'd1,
    HOP_RESP = 2'd2
  } hop_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_TX_FIRST,
    ST_TX_SECOND,
    ST_EARLY,
    ST_LISTEN,
    ST_SCAN,
    ST_SCAN_WAIT,
    ST_FIN
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic sendId;
    logic sendFhs;
    logic loadHop;
    logic hopNext;
    hop_e hopSel;
    logic startWait;
    logic finish;
  } ctrl_stb_t;

endpackage

// File: rtl/inq_slot_dpath.sv
module inq_slot_dpath
  import inq_slot_pkg::*;
#(
  parameter int CLK_W     = 17,
  parameter int HALF_SLOT = 625,
  parameter int UNC_DELAY = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic [CLK_W-1:0] nativeClk,
  input  ctrl_stb_t        stb,
  output logic             earlyHit,
  output logic             waitHit,
  output logic             idTx,
  output logic             fhsTx,
  output logic             nInc,
  output logic             done,
  output logic [1:0]       hopSel,
  output logic [CLK_W-1:0] hopClk
);

  localparam int EARLY_AT  = HALF_SLOT - UNC_DELAY;
  localparam int RESP_WAIT = 2 * HALF_SLOT;
  localparam int TMR_W     = $clog2(RESP_WAIT + 1);

  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] elapsed;
  logic [TMR_W-1:0] waitCnt;

  // fine timer: cycles since the last half-slot tick, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (halfTick) begin
      tmr <= TMR_W'(1);
    end else if (tmr != '1) begin
      tmr <= tmr + TMR_W'(1);
    end
  end

  assign elapsed  = halfTick ? '0 : tmr;
  assign earlyHit = (elapsed == TMR_W'(EARLY_AT - 1));

  // response delay counter, started by the control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (stb.startWait) begin
      waitCnt <= TMR_W'(1);
    end else if (waitCnt != '1) begin
      waitCnt <= waitCnt + TMR_W'(1);
    end
  end

  assign waitHit = (waitCnt == TMR_W'(RESP_WAIT - 1));

  // registered strobes and hop selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idTx   <= 1'b0;
      fhsTx  <= 1'b0;
      nInc   <= 1'b0;
      done   <= 1'b0;
      hopSel <= HOP_INQ;
      hopClk <= '0;
    end else begin
      idTx  <= stb.sendId;
      fhsTx <= stb.sendFhs;
      nInc  <= stb.sendFhs;
      done  <= stb.finish;
      if (stb.loadHop) begin
        hopSel <= stb.hopSel;
        hopClk <= stb.hopNext ? nativeClk + CLK_W'(1) : nativeClk;
      end
    end
  end

endmodule

// File: rtl/inq_slot_ctrl.sv
module inq_slot_ctrl
  import inq_slot_pkg::*;
#(
  parameter int CLK_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic [CLK_W-1:0] nativeClk,
  input  logic             roleInquirer,
  input  logic             idRxDet,
  input  logic             fhsRxDet,
  input  logic             earlyHit,
  input  logic             waitHit,
  output ctrl_stb_t        stb,
  output logic             rxEn,
  output logic             finished
);

  state_e state;
  state_e stateNxt;
  logic   clkAllOnes;

  assign clkAllOnes = &nativeClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (!clkAllOnes) begin
          if (roleInquirer) begin
            stateNxt = ST_ALIGN;
          end else begin
            stb.loadHop = 1'b1;
            stb.hopSel  = HOP_SCAN;
            stateNxt    = ST_SCAN;
          end
        end
      end
      ST_ALIGN: begin
        if (nativeClk[1:0] == 2'b00) begin
          stb.sendId  = 1'b1;
          stb.loadHop = 1'b1;
          stb.hopSel  = HOP_INQ;
          stateNxt    = ST_TX_FIRST;
        end
      end
      ST_TX_FIRST: begin
        if (nativeClk[0]) begin
          stb.sendId  = 1'b1;
          stb.loadHop = 1'b1;
          stb.hopSel  = HOP_INQ;
          stateNxt    = ST_TX_SECOND;
        end
      end
      ST_TX_SECOND: begin
        if (earlyHit) begin
          stb.loadHop = 1'b1;
          stb.hopNext = 1'b1;
          stb.hopSel  = HOP_RESP;
          stateNxt    = ST_EARLY;
        end
      end
      ST_EARLY: begin
        if (fhsRxDet) begin
          stb.finish = 1'b1;
          stateNxt   = ST_FIN;
        end else if (nativeClk[1]) begin
          stb.loadHop = 1'b1;
          stb.hopSel  = HOP_RESP;
          stateNxt    = ST_LISTEN;
        end
      end
      ST_LISTEN: begin
        if (fhsRxDet) begin
          stb.finish = 1'b1;
          stateNxt   = ST_FIN;
        end else if (!nativeClk[1]) begin
          stateNxt = ST_ALIGN;
        end
      end
      ST_SCAN: begin
        if (idRxDet) begin
          stb.startWait = 1'b1;
          stateNxt      = ST_SCAN_WAIT;
        end else if (halfTick) begin
          stb.loadHop = 1'b1;
          stb.hopSel  = HOP_SCAN;
        end
      end
      ST_SCAN_WAIT: begin
        if (waitHit) begin
          stb.sendFhs = 1'b1;
          stb.finish  = 1'b1;
          stb.loadHop = 1'b1;
          stb.hopSel  = HOP_RESP;
          stateNxt    = ST_FIN;
        end
      end
      ST_FIN: begin
        stateNxt = ST_FIN;
      end
      default: begin
        stateNxt = ST_IDLE;
      end
    endcase
  end

  assign rxEn     = (state == ST_EARLY) || (state == ST_LISTEN) || (state == ST_SCAN);
  assign finished = (state == ST_FIN);

endmodule

// File: rtl/inquiry_slot_ctrl.sv
module inquiry_slot_ctrl
  import inq_slot_pkg::*;
#(
  parameter int CLK_W     = 17,
  parameter int HALF_SLOT = 625,
  parameter int UNC_DELAY = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic [CLK_W-1:0] nativeClk,
  input  logic             roleInquirer,
  input  logic             idRxDet,
  input  logic             fhsRxDet,
  output logic             idTx,
  output logic             fhsTx,
  output logic             nInc,
  output logic             rxEn,
  output logic [1:0]       hopSel,
  output logic [CLK_W-1:0] hopClk,
  output logic             done,
  output logic             finished
);

  ctrl_stb_t stb;
  logic      earlyHit;
  logic      waitHit;

  inq_slot_ctrl #(.CLK_W(CLK_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .halfTick     (halfTick),
    .nativeClk    (nativeClk),
    .roleInquirer (roleInquirer),
    .idRxDet      (idRxDet),
    .fhsRxDet     (fhsRxDet),
    .earlyHit     (earlyHit),
    .waitHit      (waitHit),
    .stb          (stb),
    .rxEn         (rxEn),
    .finished     (finished)
  );

  inq_slot_dpath #(
    .CLK_W     (CLK_W),
    .HALF_SLOT (HALF_SLOT),
    .UNC_DELAY (UNC_DELAY)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .halfTick  (halfTick),
    .nativeClk (nativeClk),
    .stb       (stb),
    .earlyHit  (earlyHit),
    .waitHit   (waitHit),
    .idTx      (idTx),
    .fhsTx     (fhsTx),
    .nInc      (nInc),
    .done      (done),
    .hopSel    (hopSel),
    .hopClk    (hopClk)
  );

endmodule

// File: rtl/inquiry_slot_chk.sv
module inquiry_slot_chk (
  input logic       clk,
  input logic       rstN,
  input logic       fhsRxDet,
  input logic       idTx,
  input logic       fhsTx,
  input logic       nInc,
  input logic       rxEn,
  input logic [1:0] hopSel,
  input logic       done,
  input logic       finished
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  finished_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    finished |=> finished);

  // R9
  quiet_after_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    (finished && $past(finished)) |-> (!idTx && !fhsTx && !rxEn));

  // R8
  fhs_bundle_chk: assert property (@(posedge clk) disable iff (!rstN)
    fhsTx |-> (nInc && done && hopSel == 2'd2));

  // R6
  finish_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(finished) && !fhsTx) |-> $past(fhsRxDet && rxEn));

  // R2
  id_hop_chk: assert property (@(posedge clk) disable iff (!rstN)
    idTx |-> (hopSel == 2'd0 && !rxEn));

endmodule

bind inquiry_slot_ctrl inquiry_slot_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .fhsRxDet (fhsRxDet),
  .idTx     (idTx),
  .fhsTx    (fhsTx),
  .nInc     (nInc),
  .rxEn     (rxEn),
  .hopSel   (hopSel),
  .done     (done),
  .finished (finished)
);

// File: tb/test_inquiry_slot_ctrl.sv
`timescale 1ns/1ps
module test_inquiry_slot_ctrl;

  localparam int CLK_W     = 17;
  localparam int HALF_SLOT = 625;
  localparam int UNC_DELAY = 10;
  localparam int LIMIT     = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             halfTick = 1'b0;
  logic [CLK_W-1:0] nativeClk = '0;
  logic             roleInquirer = 1'b0;
  logic             idRxDet = 1'b0;
  logic             fhsRxDet = 1'b0;
  logic             idTx, fhsTx, nInc, rxEn, done, finished;
  logic [1:0]       hopSel;
  logic [CLK_W-1:0] hopClk;

  int  nChecks = 0;
  int  nFails  = 0;
  int  cycles  = 0;
  int  phase   = 0;
  bit  tickRun = 1'b0;

  inquiry_slot_ctrl #(
    .CLK_W(CLK_W), .HALF_SLOT(HALF_SLOT), .UNC_DELAY(UNC_DELAY)
  ) i_inquiry_slot_ctrl (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .nativeClk(nativeClk),
    .roleInquirer(roleInquirer), .idRxDet(idRxDet), .fhsRxDet(fhsRxDet),
    .idTx(idTx), .fhsTx(fhsTx), .nInc(nInc), .rxEn(rxEn),
    .hopSel(hopSel), .hopClk(hopClk), .done(done), .finished(finished)
  );

  always #2.5 clk = ~clk;

  // half-slot tick and native clock driver
  always @(posedge clk) begin
    #1;
    if (tickRun) begin
      if (phase == HALF_SLOT - 1) begin
        phase     = 0;
        halfTick  = 1'b1;
        nativeClk = nativeClk + 1'b1;
      end else begin
        phase    = phase + 1;
        halfTick = 1'b0;
      end
    end else begin
      halfTick = 1'b0;
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic adv();
    @(posedge clk);
    #2;
    cycles++;
    if (cycles > LIMIT) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, LIMIT);
      finishRun();
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic [CLK_W-1:0] startClk, input logic role);
    tickRun      = 1'b0;
    rstN         = 1'b0;
    idRxDet      = 1'b0;
    fhsRxDet     = 1'b0;
    roleInquirer = role;
    repeat (3) adv();
    nativeClk = startClk;
    phase     = 0;
    tickRun   = 1'b1;
    rstN      = 1'b1;
  endtask

  task automatic waitTickVal(input logic [CLK_W-1:0] v);
    do adv(); while (!(halfTick && nativeClk == v));
  endtask

  // Scanner flow: idle hold, scan hop tracking, delayed FHS response
  task automatic scannerTest();
    bit quiet = 1'b1;
    logic [CLK_W-1:0] clkAt;
    doReset('1, 1'b0);
    // R1 reset state
    chk(idTx == 0 && fhsTx == 0 && nInc == 0 && done == 0, "R1", "strobes after reset",
        {idTx, fhsTx, nInc, done}, 0);
    chk(rxEn == 0 && finished == 0, "R1", "rxEn/finished after reset", {rxEn, finished}, 0);
    // R1 idle while clock is all ones
    do begin
      adv();
      if (rxEn !== 1'b0) quiet = 1'b0;
    end while (!halfTick);
    chk(quiet, "R1", "rxEn while clock all ones", !quiet, 0);
    chk(nativeClk == 0, "R1", "clock wrapped", nativeClk, 0);
    adv();
    // R1 leaves idle, R7 scan hop loaded
    chk(rxEn == 1, "R1", "scanner leaves idle", rxEn, 1);
    chk(hopSel == 2'd1 && hopClk == 0, "R7", "scan hop at start", hopClk, 0);
    waitTickVal(1);
    adv();
    chk(hopClk == 1 && hopSel == 2'd1, "R7", "scan hop follows clock", hopClk, 1);
    roleInquirer = 1'b1;  // R10: must not matter now
    repeat (100) adv();
    chk(idTx == 0 && rxEn == 1, "R10", "role change ignored while scanning", idTx, 0);
    idRxDet = 1'b1;
    adv();
    idRxDet = 1'b0;
    chk(rxEn == 0, "R8", "rxEn drops after ID", rxEn, 0);
    clkAt = '0;
    for (int i = 2; i <= 2 * HALF_SLOT; i++) begin
      if (i == 2 * HALF_SLOT) clkAt = nativeClk;
      adv();
      if (i == 2 * HALF_SLOT - 1) chk(fhsTx == 0, "R8", "FHS not early", fhsTx, 0);
    end
    chk(fhsTx == 1 && nInc == 1, "R8", "FHS and N increment at 1250", {fhsTx, nInc}, 3);
    chk(hopSel == 2'd2 && hopClk == clkAt, "R8", "response hop clock", hopClk, clkAt);
    chk(done == 1 && finished == 1, "R9", "done on scanner finish", done, 1);
    adv();
    chk(done == 0 && fhsTx == 0 && finished == 1, "R9", "done one cycle, finished sticky",
        {done, fhsTx, finished}, 1);
  endtask

  // Inquirer flow: ID pair, early window, listen slot, finish on FHS
  task automatic inquirerTest();
    bit quiet = 1'b1;
    doReset(1, 1'b1);
    do begin
      adv();
      if (idTx !== 1'b0) quiet = 1'b0;
    end while (!(halfTick && nativeClk[1:0] == 2'b00));
    chk(quiet, "R2", "no ID before slot boundary", !quiet, 0);
    chk(nativeClk == 4, "R2", "boundary clock", nativeClk, 4);
    adv();
    chk(idTx == 1 && hopSel == 2'd0 && hopClk == 4, "R2", "first ID hop clock", hopClk, 4);
    adv();
    chk(idTx == 0, "R2", "ID one cycle", idTx, 0);
    roleInquirer = 1'b0;  // R10: must not matter now
    waitTickVal(5);
    adv();
    chk(idTx == 1 && hopClk == 5, "R3", "second ID hop clock", hopClk, 5);
    chk(idTx == 1, "R10", "inquirer kept after role change", idTx, 1);
    for (int i = 2; i <= HALF_SLOT - UNC_DELAY; i++) begin
      adv();
      if (i == HALF_SLOT - UNC_DELAY - 1) chk(rxEn == 0, "R4", "window not early", rxEn, 0);
    end
    chk(rxEn == 1 && hopSel == 2'd2, "R4", "early window opens", rxEn, 1);
    chk(hopClk == 6, "R4", "early hop uses clock plus one", hopClk, 6);
    waitTickVal(6);
    adv();
    chk(rxEn == 1 && hopClk == 6, "R5", "listen on current clock", hopClk, 6);
    waitTickVal(8);
    adv();
    chk(rxEn == 0, "R5", "rxEn falls when bit 1 clears", rxEn, 0);
    adv();
    chk(idTx == 1 && hopClk == 8, "R5", "next ID after listen slot", hopClk, 8);
    // R6: FHS detect outside the window is ignored
    repeat (20) adv();
    fhsRxDet = 1'b1;
    adv();
    fhsRxDet = 1'b0;
    adv();
    chk(finished == 0 && done == 0, "R6", "FHS ignored while rxEn low", finished, 0);
    waitTickVal(9);
    adv();
    chk(idTx == 1 && hopClk == 9, "R3", "second ID of next slot", hopClk, 9);
    do adv(); while (!rxEn);
    chk(hopClk == 10, "R4", "second early window hop", hopClk, 10);
    fhsRxDet = 1'b1;
    adv();
    fhsRxDet = 1'b0;
    chk(done == 1 && finished == 1, "R6", "FHS in window finishes", {done, finished}, 3);
    chk(fhsTx == 0 && nInc == 0, "R6", "inquirer sends no FHS", {fhsTx, nInc}, 0);
    adv();
    chk(done == 0 && finished == 1, "R9", "done pulse one cycle", done, 0);
    quiet = 1'b1;
    repeat (3 * HALF_SLOT) begin
      adv();
      if (idTx || rxEn || !finished) quiet = 1'b0;
    end
    chk(quiet, "R9", "quiet and sticky after finish", !quiet, 0);
  endtask

  initial begin
    scannerTest();
    inquirerTest();
    finishRun();
  end

endmodule